// File: doc/BRIEF.md
# Frame-Synchronised Stereo Serial Receiver

This block takes stereo PCM audio from the serial port of a host signal processor and turns it into parallel samples. It runs directly on the serial bit clock. A single falling edge on the frame-sync line opens a frame. The left-channel word arrives first, MSB first. The right-channel word follows on the very next bit clock, with no idle bits between the words and no second sync. When the right word's LSB has been taken in, both samples are loaded into the output registers together and a one-cycle valid strobe is raised.

The word length `WORD_W` is a parameter, meant for 16, 20, 24 or 32 bits. A controller built around an enumerated state drives the datapath, and it has three states:
- `ST_IDLE` waits for a frame and ignores the data line.
- `ST_LEFT` gathers the left word.
- `ST_RIGHT` gathers the right word.

The transitions are:
- *frame start*: any state goes to `ST_LEFT` on a falling sync edge. This edge takes priority over everything else, so it also restarts a frame that is still in progress.
- *left done*: `ST_LEFT` goes to `ST_RIGHT` after the left word's LSB.
- *pair done*: `ST_RIGHT` goes to `ST_IDLE` after the right word's LSB, and valid is raised.
- *wait*: `ST_IDLE` stays in `ST_IDLE` while no falling edge is seen.

Top module: `dsp_frame_rx`

## Requirements
- R1: While `rst_n` is low, `valid_o`, `left_o` and `right_o` are all zero.
- R2: The sync and data lines are sampled on the rising bit clock. A frame starts at a rising edge where `fsync` is sampled low after being sampled high at the previous edge. The data bit sampled at that same edge is the left word's MSB.
- R3: The next `WORD_W` bits, counting the MSB, form `left_o`, MSB first. Bit `WORD_W-1` of the output is the first bit received.
- R4: The right word's MSB is sampled at the edge right after the left word's LSB. `right_o` is built from the following `WORD_W` bits in the same MSB-first order.
- R5: Consider the edge that samples the right word's LSB. After that edge, `valid_o` is high for exactly one cycle, and `left_o` and `right_o` carry the new pair during that same cycle.
- R6: While `valid_o` is low, `left_o` and `right_o` keep their values.
- R7: After the right word's LSB, and until the next falling sync edge, data bits are ignored. A sync line that stays low, or stays high, does not start a frame.
- R8: A falling sync edge that arrives before the right word's LSB has been sampled throws away the partial frame, with no valid. A new frame starts at that edge, and the bit sampled there becomes the new left MSB.
- R9: A falling sync edge at the edge right after a right LSB starts the next frame with no lost bit. This allows frames to run back to back.
- R10: The sync history is cleared to low by reset. A line that is already low when reset is released does not start a frame until it has been seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync from the host port; falling edge opens a frame |
| sdata | input | 1 | Serial data, MSB first, left word then right word |
| left_o | output | WORD_W | Last complete left-channel sample |
| right_o | output | WORD_W | Last complete right-channel sample |
| valid_o | output | 1 | One-cycle strobe when a new stereo pair is loaded |

## Verification
A bit counter that is off by one would show up within the first frame. Both words would come out shifted by one position, and valid would arrive a cycle early or late relative to the frame-start edge plus `2*WORD_W` edges. If the controller is stuck in the wrong state after a truncated frame or a sync line held low, the effect would be a spurious valid, or a missing one, on the next frame. The bench samples every cycle of every frame for stray valids, so such a fault is seen within `2*WORD_W` bit clocks.

// File: rtl/dspfr_pkg.sv
package dspfr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } rx_state_t;

endpackage

// File: rtl/dspfr_edge.sv
module dspfr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic fall
);

    // Previous sampled sync level; cleared so a line low at reset is not an edge.
    logic fs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= 1'b0;
        end else begin
            fs_q <= fsync;
        end
    end

    assign fall = fs_q & ~fsync;

endmodule

// File: rtl/dspfr_ctrl.sv
module dspfr_ctrl
    import dspfr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fall,
    output rx_state_t state,
    output logic      start,
    output logic      shift_en,
    output logic      end_left,
    output logic      end_right,
    output logic      valid
);

    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             last_bit;

    always_comb begin
        start     = fall;
        shift_en  = !fall && (state != ST_IDLE);
        last_bit  = (cnt == LAST);
        end_left  = shift_en && (state == ST_LEFT) && last_bit;
        end_right = shift_en && (state == ST_RIGHT) && last_bit;
    end

    // State register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (fall) begin
            state <= ST_LEFT;
            cnt   <= ONE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
                ST_LEFT: begin
                    if (last_bit) begin
                        state <= ST_RIGHT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                ST_RIGHT: begin
                    if (last_bit) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            valid <= end_right;
        end
    end

    // R8
    fall_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (state == ST_LEFT) && (cnt == ONE));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R5
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($past(state) == ST_RIGHT));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && !fall |=> (state == ST_IDLE) && !valid);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/dspfr_shift.sv
module dspfr_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shift_en,
    input  logic              end_left,
    input  logic              end_right,
    input  logic              sdata,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o
);

    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] left_hold;

    always_comb begin
        if (start) begin
            nxt = {{(WORD_W-1){1'b0}}, sdata};
        end else begin
            nxt = {sh[WORD_W-2:0], sdata};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '0;
            left_hold <= '0;
            left_o    <= '0;
            right_o   <= '0;
        end else begin
            if (start || shift_en) begin
                sh <= nxt;
            end
            if (end_left) begin
                left_hold <= nxt;
            end
            if (end_right) begin
                left_o  <= left_hold;
                right_o <= nxt;
            end
        end
    end

endmodule

// File: rtl/dsp_frame_rx.sv
module dsp_frame_rx
    import dspfr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              sdata,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);

    logic      fall;
    rx_state_t state;
    logic      start;
    logic      shift_en;
    logic      end_left;
    logic      end_right;

    dspfr_edge u_edge (
        .clk   (bclk),
        .rst_n (rst_n),
        .fsync (fsync),
        .fall  (fall)
    );

    dspfr_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (bclk),
        .rst_n     (rst_n),
        .fall      (fall),
        .state     (state),
        .start     (start),
        .shift_en  (shift_en),
        .end_left  (end_left),
        .end_right (end_right),
        .valid     (valid_o)
    );

    dspfr_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (bclk),
        .rst_n     (rst_n),
        .start     (start),
        .shift_en  (shift_en),
        .end_left  (end_left),
        .end_right (end_right),
        .sdata     (sdata),
        .left_o    (left_o),
        .right_o   (right_o)
    );

    // R6
    hold_out_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        !valid_o |-> $stable(left_o) && $stable(right_o));

    // R1
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            reset_out_chk: assert (!valid_o && left_o == '0 && right_o == '0);
        end
    end

endmodule

// File: tb/test_dsp_frame_rx.sv
module test_dsp_frame_rx;

    localparam int W = 16;

    logic         bclk  = 1'b0;
    logic         rst_n = 1'b0;
    logic         fsync = 1'b1;
    logic         sdata = 1'b0;
    logic [W-1:0] left_o;
    logic [W-1:0] right_o;
    logic         valid_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] last_l = '0;
    logic [W-1:0] last_r = '0;

    // {gap_after, left, right}
    localparam logic [32:0] VEC [6] = '{
        33'h1_8000_0001,
        33'h0_0001_8000,
        33'h0_A5C3_3C5A,
        33'h1_FFFF_0000,
        33'h0_0000_FFFF,
        33'h1_1234_FEDC
    };

    dsp_frame_rx #(.WORD_W(W)) i_dsp_frame_rx (
        .bclk    (bclk),
        .rst_n   (rst_n),
        .fsync   (fsync),
        .sdata   (sdata),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    always #5 bclk = ~bclk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives nbits of a frame starting at a negedge; returns stray valids.
    task automatic send_bits(input logic [W-1:0] l, input logic [W-1:0] r,
                             input int nbits, input bit hold_low, output int stray);
        stray = 0;
        for (int i = 0; i < nbits; i++) begin
            fsync = (i == 0 || hold_low) ? 1'b0 : 1'b1;
            sdata = (i < W) ? l[W-1-i] : r[2*W-1-i];
            @(negedge bclk);
            if (i != 2*W-1 && valid_o) stray++;
        end
    endtask

    task automatic full_frame(input logic [W-1:0] l, input logic [W-1:0] r,
                              input bit hold_low, input string tag);
        int stray;
        send_bits(l, r, 2*W, hold_low, stray);
        chk({"R5 valid after right LSB ", tag}, 32'(valid_o), 32'd1);
        chk({"R2 R3 left word ", tag}, 32'(left_o), 32'(l));
        chk({"R4 right word ", tag}, 32'(right_o), 32'(r));
        chk({"R5 no stray valid ", tag}, 32'(stray), 32'd0);
        last_l = l;
        last_r = r;
    endtask

    task automatic idle(input int n, input bit low, output int nvalid);
        nvalid = 0;
        for (int i = 0; i < n; i++) begin
            fsync = low ? 1'b0 : 1'b1;
            sdata = 1'($urandom);
            @(negedge bclk);
            if (valid_o) nvalid++;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int nv;
        int stray;
        logic [W-1:0] a;
        logic [W-1:0] b;

        // R1 reset state
        repeat (3) @(negedge bclk);
        chk("R1 valid in reset", 32'(valid_o), 32'd0);
        chk("R1 left in reset", 32'(left_o), 32'd0);
        chk("R1 right in reset", 32'(right_o), 32'd0);
        rst_n = 1'b1;
        idle(2, 1'b0, nv);

        // Table walk; entries without gap run back to back (R9)
        for (int k = 0; k < 6; k++) begin
            full_frame(VEC[k][31:16], VEC[k][15:0], 1'b0, "table");
            if (VEC[k][32]) begin
                idle(3, 1'b0, nv);
                chk("R7 no valid in gap", 32'(nv), 32'd0);
                chk("R6 left held", 32'(left_o), 32'(last_l));
                chk("R6 right held", 32'(right_o), 32'(last_r));
            end
        end

        // R9 random back-to-back pairs
        for (int k = 0; k < 8; k++) begin
            full_frame(W'($urandom), W'($urandom), 1'b0, "R9 back-to-back");
        end

        // R7 long run of trailing bits, sync high
        idle(2*W + 3, 1'b0, nv);
        chk("R7 trailing bits ignored", 32'(nv), 32'd0);
        chk("R6 left unchanged", 32'(left_o), 32'(last_l));
        chk("R6 right unchanged", 32'(right_o), 32'(last_r));

        // R8 truncated frames at several depths
        send_bits(16'hDEAD, 16'hBEEF, 5, 1'b0, stray);
        chk("R8 no valid early truncation", 32'(stray), 32'd0);
        full_frame(16'h0F0F, 16'hF0F0, 1'b0, "R8 after 5 bits");
        send_bits(16'hDEAD, 16'hBEEF, W + 3, 1'b0, stray);
        chk("R8 no valid mid-right truncation", 32'(stray), 32'd0);
        full_frame(16'h1357, 16'h2468, 1'b0, "R8 after W+3 bits");
        send_bits(16'hDEAD, 16'hBEEF, 2*W - 1, 1'b0, stray);
        chk("R8 no valid when LSB replaced", 32'(stray), 32'd0);
        full_frame(16'h7FFE, 16'h8001, 1'b0, "R8 restart on last bit");

        // R7 sync held low through and after a frame
        a = W'($urandom);
        b = W'($urandom);
        full_frame(a, b, 1'b1, "R7 sync held low");
        idle(2*W, 1'b1, nv);
        chk("R7 low level starts nothing", 32'(nv), 32'd0);
        chk("R7 left unchanged low", 32'(left_o), 32'(a));
        idle(1, 1'b0, nv);
        full_frame(16'hC001, 16'h00C3, 1'b0, "R7 after low");

        // R10 reset with sync already low
        rst_n = 1'b0;
        fsync = 1'b0;
        repeat (2) @(negedge bclk);
        chk("R1 left cleared by reset", 32'(left_o), 32'd0);
        chk("R1 right cleared by reset", 32'(right_o), 32'd0);
        rst_n = 1'b1;
        idle(2*W + 2, 1'b1, nv);
        chk("R10 low at release is no edge", 32'(nv), 32'd0);
        chk("R10 outputs stay clear", 32'(left_o), 32'd0);
        idle(1, 1'b0, nv);
        full_frame(16'h5A5A, 16'hA5A5, 1'b0, "R10 first frame");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule